// File: doc/BRIEF.md
# Sixteen-Bit ALU with Registered Status Word

The block is a combinational arithmetic and logic unit for 16-bit operands. It holds a nine-bit flag word in a register next to it. Each cycle it takes two operands, an operation code and a byte/word size select. It drives the result on the same cycle. When the update enable is high, the matching status flags are written into the flag word on the next rising clock edge.

Six flags describe the last result: carry, auxiliary carry, parity, zero, sign and overflow. Three control flags sit in the same word: trap, interrupt enable and direction. They change only through an explicit set or clear command. A status update can never disturb them, and a control command can never disturb the status flags. In byte mode only the low eight bits of each operand take part. All flags then use bit 7 as the top bit.

Top module: `alu_status_unit`

## Requirements
- R1: `op_i` selects the operation: 0 add, 1 subtract (a minus b), 2 increment a, 3 decrement a, 4 AND, 5 OR, 6 XOR. The result is taken modulo the operand width. Increment and decrement ignore `b_i`.
- R2: With `byte_mode_i` high, only bits 7:0 of each operand are used, and bits 15:8 of `result_o` are zero.
- R3: Carry (flags bit 0) is set after an add or subtract that carries or borrows out of the top bit (bit 15 for words, bit 7 for bytes), and cleared otherwise.
- R4: Auxiliary carry (flags bit 1) is set after an arithmetic operation, increment and decrement included, when a carry or borrow crosses from bit 3 into bit 4.
- R5: Parity (flags bit 2) is set when bits 7:0 of the result hold an even number of ones, for both sizes.
- R6: Zero (flags bit 3) is set exactly when the result is zero.
- R7: Sign (flags bit 4) copies the top bit of the result (bit 15 for words, bit 7 for bytes).
- R8: Overflow (flags bit 5) is set when a signed add, subtract, increment or decrement gives a result that does not fit the operand width.
- R9: AND, OR and XOR clear carry and overflow, keep auxiliary carry, and update parity, zero and sign.
- R10: Increment and decrement update every status flag except carry, which keeps its previous value.
- R11: Flags change only on a rising edge with `flag_we_i` high. Op codes 7 to 15 leave all flags unchanged and drive `result_o` equal to `a_i`.
- R12: With `ctl_we_i` high, the flag chosen by `ctl_sel_i` is written with `ctl_val_i`: 0 trap (flags bit 6), 1 interrupt enable (bit 7), 2 direction (bit 8). Select 3 has no effect. Control flags change by no other path, and a command never changes a status flag.
- R13: A synchronous, active-high `rst` clears all nine flag bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_i | input | 4 | Operation code |
| byte_mode_i | input | 1 | High for 8-bit operation |
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| flag_we_i | input | 1 | Write status flags on this edge |
| ctl_we_i | input | 1 | Apply a control flag command |
| ctl_sel_i | input | 2 | Control flag choice |
| ctl_val_i | input | 1 | Value written to the chosen control flag |
| result_o | output | 16 | Combinational result |
| flags_o | output | 9 | Registered flag word |

## Verification
The result path has no state, so a wrong operation or a wrong size mask shows on `result_o` in the same cycle the operands are applied. A flag computed wrongly, or a flag the wrong class of operation keeps or clears, shows on `flags_o` one edge after the update. Some faults show only later. A carry that increment fails to keep, or an auxiliary carry that a logical operation fails to keep, needs the earlier state set up first. The stimulus table is therefore ordered so that each such operation follows one that left the flag at a known, non-reset value.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_INC = 4'd2,
        OP_DEC = 4'd3,
        OP_AND = 4'd4,
        OP_OR  = 4'd5,
        OP_XOR = 4'd6
    } alu_op_e;

    typedef enum logic [1:0] {
        CLS_NONE  = 2'd0,
        CLS_ARITH = 2'd1,
        CLS_STEP  = 2'd2,
        CLS_LOGIC = 2'd3
    } op_class_e;

    typedef enum logic [1:0] {
        CTL_TRAP = 2'd0,
        CTL_IEN  = 2'd1,
        CTL_DIR  = 2'd2,
        CTL_NOP  = 2'd3
    } ctl_sel_e;

    typedef struct packed {
        logic ovf;
        logic sgn;
        logic zro;
        logic par;
        logic aux;
        logic cry;
    } status_t;

    typedef struct packed {
        logic dir;
        logic ien;
        logic trap;
    } control_t;

    typedef struct packed {
        control_t ctl;
        status_t  st;
    } flag_word_t;

endpackage

// File: rtl/alu_datapath.sv
module alu_datapath
    import alu_flags_pkg::*;
#(
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned BYTE_W  = 8,
    parameter int unsigned AUX_POS = 4
) (
    input  logic [3:0]        op_i,
    input  logic              byte_mode_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] result_o,
    output status_t           raw_o,
    output op_class_e         cls_o
);
    localparam int unsigned EXT_W = DATA_W + 1;
    localparam logic [DATA_W-1:0] BYTE_MASK = {{(DATA_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};
    localparam logic [DATA_W-1:0] ONE       = {{(DATA_W-1){1'b0}}, 1'b1};

    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] opa, opb;
    logic [EXT_W-1:0]  sum_w, diff_w, wide;
    logic [DATA_W-1:0] res;
    logic [DATA_W-1:0] aux_vec;
    logic              is_sub;
    logic              a_top, b_top, r_top;

    always_comb begin
        mask   = byte_mode_i ? BYTE_MASK : '1;
        opa    = a_i & mask;
        opb    = ((op_i == OP_INC) || (op_i == OP_DEC)) ? ONE : (b_i & mask);
        sum_w  = {1'b0, opa} + {1'b0, opb};
        diff_w = {1'b0, opa} - {1'b0, opb};
        is_sub = 1'b0;
        cls_o  = CLS_NONE;
        wide   = {1'b0, a_i};
        case (op_i)
            OP_ADD: begin wide = sum_w;  cls_o = CLS_ARITH; end
            OP_SUB: begin wide = diff_w; cls_o = CLS_ARITH; is_sub = 1'b1; end
            OP_INC: begin wide = sum_w;  cls_o = CLS_STEP; end
            OP_DEC: begin wide = diff_w; cls_o = CLS_STEP;  is_sub = 1'b1; end
            OP_AND: begin wide = {1'b0, opa & opb}; cls_o = CLS_LOGIC; end
            OP_OR:  begin wide = {1'b0, opa | opb}; cls_o = CLS_LOGIC; end
            OP_XOR: begin wide = {1'b0, opa ^ opb}; cls_o = CLS_LOGIC; end
            default: ;
        endcase
        res      = (cls_o == CLS_NONE) ? a_i : (wide[DATA_W-1:0] & mask);
        result_o = res;

        a_top   = byte_mode_i ? opa[BYTE_W-1] : opa[DATA_W-1];
        b_top   = byte_mode_i ? opb[BYTE_W-1] : opb[DATA_W-1];
        r_top   = byte_mode_i ? res[BYTE_W-1] : res[DATA_W-1];
        aux_vec = opa ^ opb ^ res;

        raw_o.cry = byte_mode_i ? wide[BYTE_W] : wide[DATA_W];
        raw_o.aux = aux_vec[AUX_POS];
        raw_o.par = ~^res[BYTE_W-1:0];
        raw_o.zro = (res == '0);
        raw_o.sgn = r_top;
        raw_o.ovf = is_sub ? ((a_top != b_top) && (r_top != a_top))
                           : ((a_top == b_top) && (r_top != a_top));
    end

endmodule

// File: rtl/alu_flag_next.sv
module alu_flag_next
    import alu_flags_pkg::*;
(
    input  flag_word_t cur_i,
    input  status_t    raw_i,
    input  op_class_e  cls_i,
    input  logic       flag_we_i,
    input  logic       ctl_we_i,
    input  logic [1:0] ctl_sel_i,
    input  logic       ctl_val_i,
    output flag_word_t nxt_o
);
    always_comb begin
        nxt_o = cur_i;
        if (flag_we_i) begin
            case (cls_i)
                CLS_ARITH: nxt_o.st = raw_i;
                CLS_STEP: begin
                    nxt_o.st     = raw_i;
                    nxt_o.st.cry = cur_i.st.cry;
                end
                CLS_LOGIC: begin
                    nxt_o.st     = raw_i;
                    nxt_o.st.cry = 1'b0;
                    nxt_o.st.ovf = 1'b0;
                    nxt_o.st.aux = cur_i.st.aux;
                end
                default: ;
            endcase
        end
        if (ctl_we_i) begin
            case (ctl_sel_i)
                CTL_TRAP: nxt_o.ctl.trap = ctl_val_i;
                CTL_IEN:  nxt_o.ctl.ien  = ctl_val_i;
                CTL_DIR:  nxt_o.ctl.dir  = ctl_val_i;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/alu_status_unit.sv
module alu_status_unit
    import alu_flags_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        op_i,
    input  logic              byte_mode_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              flag_we_i,
    input  logic              ctl_we_i,
    input  logic [1:0]        ctl_sel_i,
    input  logic              ctl_val_i,
    output logic [DATA_W-1:0] result_o,
    output logic [8:0]        flags_o
);
    typedef struct packed {
        flag_word_t flags;
    } state_t;

    state_t     state_d, state_q;
    status_t    raw_w;
    op_class_e  cls_w;
    flag_word_t nxt_w;

    alu_datapath #(
        .DATA_W (DATA_W),
        .BYTE_W (BYTE_W)
    ) u_datapath (
        .op_i        (op_i),
        .byte_mode_i (byte_mode_i),
        .a_i         (a_i),
        .b_i         (b_i),
        .result_o    (result_o),
        .raw_o       (raw_w),
        .cls_o       (cls_w)
    );

    alu_flag_next u_flag_next (
        .cur_i     (state_q.flags),
        .raw_i     (raw_w),
        .cls_i     (cls_w),
        .flag_we_i (flag_we_i),
        .ctl_we_i  (ctl_we_i),
        .ctl_sel_i (ctl_sel_i),
        .ctl_val_i (ctl_val_i),
        .nxt_o     (nxt_w)
    );

    always_comb begin
        state_d       = state_q;
        state_d.flags = nxt_w;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    assign flags_o = state_q.flags;

endmodule

// File: rtl/alu_status_checker.sv
module alu_status_checker #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned BYTE_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [3:0]        op_i,
    input logic              byte_mode_i,
    input logic [DATA_W-1:0] a_i,
    input logic              flag_we_i,
    input logic              ctl_we_i,
    input logic [1:0]        ctl_sel_i,
    input logic              ctl_val_i,
    input logic [DATA_W-1:0] result_o,
    input logic [8:0]        flags_o
);
    a_r13_reset_clears: assert property (@(posedge clk)
        rst |=> (flags_o == 9'd0));

    a_r11_status_hold: assert property (@(posedge clk) disable iff (rst)
        !flag_we_i |=> (flags_o[5:0] == $past(flags_o[5:0])));

    a_r11_unknown_op_passes_a: assert property (@(posedge clk) disable iff (rst)
        (op_i > 4'd6) |-> (result_o == a_i));

    a_r12_control_hold: assert property (@(posedge clk) disable iff (rst)
        !ctl_we_i |=> (flags_o[8:6] == $past(flags_o[8:6])));

    a_r12_trap_write: assert property (@(posedge clk) disable iff (rst)
        (ctl_we_i && ctl_sel_i == 2'd0) |=> (flags_o[6] == $past(ctl_val_i)));

    a_r2_byte_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (byte_mode_i && op_i <= 4'd6) |-> (result_o[DATA_W-1:BYTE_W] == '0));

    a_r5_parity: assert property (@(posedge clk) disable iff (rst)
        (flag_we_i && op_i <= 4'd6) |=> (flags_o[2] == ~^$past(result_o[BYTE_W-1:0])));

    a_r6_zero: assert property (@(posedge clk) disable iff (rst)
        (flag_we_i && op_i <= 4'd6) |=> (flags_o[3] == ($past(result_o) == '0)));

    a_r7_sign: assert property (@(posedge clk) disable iff (rst)
        (flag_we_i && op_i <= 4'd6) |=>
            (flags_o[4] == $past(byte_mode_i ? result_o[BYTE_W-1] : result_o[DATA_W-1])));

    a_r9_logic_clears: assert property (@(posedge clk) disable iff (rst)
        (flag_we_i && op_i >= 4'd4 && op_i <= 4'd6) |=> (!flags_o[0] && !flags_o[5]));

    a_r9_logic_keeps_aux: assert property (@(posedge clk) disable iff (rst)
        (flag_we_i && op_i >= 4'd4 && op_i <= 4'd6) |=> (flags_o[1] == $past(flags_o[1])));

    a_r10_step_keeps_carry: assert property (@(posedge clk) disable iff (rst)
        (flag_we_i && (op_i == 4'd2 || op_i == 4'd3)) |=> (flags_o[0] == $past(flags_o[0])));

endmodule

bind alu_status_unit alu_status_checker #(
    .DATA_W (DATA_W),
    .BYTE_W (BYTE_W)
) u_checker (
    .clk         (clk),
    .rst         (rst),
    .op_i        (op_i),
    .byte_mode_i (byte_mode_i),
    .a_i         (a_i),
    .flag_we_i   (flag_we_i),
    .ctl_we_i    (ctl_we_i),
    .ctl_sel_i   (ctl_sel_i),
    .ctl_val_i   (ctl_val_i),
    .result_o    (result_o),
    .flags_o     (flags_o)
);

// File: tb/alu_status_unit_bench.sv
module alu_status_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 16;

    // {op[3:0], byte, a[15:0], b[15:0], result[15:0], status{ovf,sgn,zro,par,aux,cry}}
    localparam logic [58:0] VEC [NVEC] = '{
        {4'd0, 1'b0, 16'h0001, 16'h0002, 16'h0003, 6'h04},
        {4'd0, 1'b0, 16'hFFFF, 16'h0001, 16'h0000, 6'h0F},
        {4'd0, 1'b0, 16'h7FFF, 16'h0001, 16'h8000, 6'h36},
        {4'd1, 1'b0, 16'h0000, 16'h0001, 16'hFFFF, 6'h17},
        {4'd1, 1'b0, 16'h8000, 16'h0001, 16'h7FFF, 6'h26},
        {4'd4, 1'b0, 16'hF0F0, 16'h0FFF, 16'h00F0, 6'h06},
        {4'd5, 1'b0, 16'h8000, 16'h0001, 16'h8001, 6'h12},
        {4'd6, 1'b0, 16'h1234, 16'h1234, 16'h0000, 6'h0E},
        {4'd1, 1'b1, 16'h0000, 16'h0001, 16'h00FF, 6'h17},
        {4'd2, 1'b1, 16'h007F, 16'h0055, 16'h0080, 6'h33},
        {4'd3, 1'b0, 16'h0000, 16'h0000, 16'hFFFF, 6'h17},
        {4'd0, 1'b1, 16'h1280, 16'h3480, 16'h0000, 6'h2D},
        {4'd2, 1'b0, 16'hFFFF, 16'h0000, 16'h0000, 6'h0F},
        {4'd0, 1'b1, 16'h000F, 16'h0001, 16'h0010, 6'h02},
        {4'd4, 1'b1, 16'h00FF, 16'hFF0F, 16'h000F, 6'h06},
        {4'd3, 1'b1, 16'h0080, 16'h0000, 16'h007F, 6'h22}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  op_i = '0;
    logic        byte_mode_i = 1'b0;
    logic [15:0] a_i = '0;
    logic [15:0] b_i = '0;
    logic        flag_we_i = 1'b0;
    logic        ctl_we_i = 1'b0;
    logic [1:0]  ctl_sel_i = '0;
    logic        ctl_val_i = 1'b0;
    logic [15:0] result_o;
    logic [8:0]  flags_o;

    int tests = 0;
    int fails = 0;
    bit ended = 1'b0;

    alu_status_unit u_alu_status_unit (
        .clk(clk), .rst(rst), .op_i(op_i), .byte_mode_i(byte_mode_i),
        .a_i(a_i), .b_i(b_i), .flag_we_i(flag_we_i), .ctl_we_i(ctl_we_i),
        .ctl_sel_i(ctl_sel_i), .ctl_val_i(ctl_val_i),
        .result_o(result_o), .flags_o(flags_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    task automatic check(input logic [15:0] got, input logic [15:0] exp, input string what);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", what, got, exp);
        end
    endtask

    task automatic apply(input logic [3:0] op, input logic bm, input logic [15:0] a,
                         input logic [15:0] b, input logic fwe, input logic cwe,
                         input logic [1:0] cs, input logic cv,
                         input logic [15:0] exp_res, input string what);
        @(negedge clk);
        op_i = op; byte_mode_i = bm; a_i = a; b_i = b;
        flag_we_i = fwe; ctl_we_i = cwe; ctl_sel_i = cs; ctl_val_i = cv;
        #1;
        check(result_o, exp_res, what);
        @(posedge clk);
        #1;
        flag_we_i = 1'b0; ctl_we_i = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check({7'd0, flags_o}, 16'h0000, "R13 reset state");
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            apply(VEC[i][58:55], VEC[i][54], VEC[i][53:38], VEC[i][37:22],
                  1'b1, 1'b0, 2'd0, 1'b0, VEC[i][21:6], "R1 R2 result");
            check({7'd0, flags_o}, {10'd0, VEC[i][5:0]},
                  "R3 R4 R5 R6 R7 R8 R9 R10 status flags");
        end

        // R11: no update without enable
        apply(4'd0, 1'b0, 16'h0001, 16'h0001, 1'b0, 1'b0, 2'd0, 1'b0, 16'h0002, "R11 add result");
        check({7'd0, flags_o}, 16'h0022, "R11 flags held without enable");
        // R11: unknown op code
        apply(4'hF, 1'b0, 16'hABCD, 16'h1111, 1'b1, 1'b0, 2'd0, 1'b0, 16'hABCD, "R11 unknown op result");
        check({7'd0, flags_o}, 16'h0022, "R11 unknown op keeps flags");

        // R12: control commands
        apply(4'hF, 1'b0, 16'h0000, 16'h0000, 1'b0, 1'b1, 2'd0, 1'b1, 16'h0000, "R12 idle result");
        check({7'd0, flags_o}, 16'h0062, "R12 set trap");
        apply(4'hF, 1'b0, 16'h0000, 16'h0000, 1'b0, 1'b1, 2'd2, 1'b1, 16'h0000, "R12 idle result");
        check({7'd0, flags_o}, 16'h0162, "R12 set direction");
        apply(4'hF, 1'b0, 16'h0000, 16'h0000, 1'b0, 1'b1, 2'd1, 1'b1, 16'h0000, "R12 idle result");
        check({7'd0, flags_o}, 16'h01E2, "R12 set interrupt enable");
        apply(4'hF, 1'b0, 16'h0000, 16'h0000, 1'b0, 1'b1, 2'd3, 1'b0, 16'h0000, "R12 idle result");
        check({7'd0, flags_o}, 16'h01E2, "R12 select 3 no effect");
        apply(4'hF, 1'b0, 16'h0000, 16'h0000, 1'b0, 1'b1, 2'd0, 1'b0, 16'h0000, "R12 idle result");
        check({7'd0, flags_o}, 16'h01A2, "R12 clear trap");
        apply(4'd0, 1'b0, 16'h0000, 16'h0000, 1'b1, 1'b0, 2'd0, 1'b0, 16'h0000, "R6 zero add result");
        check({7'd0, flags_o}, 16'h018C, "R12 status update keeps control flags");
        apply(4'd1, 1'b0, 16'h0005, 16'h0003, 1'b1, 1'b1, 2'd1, 1'b0, 16'h0002, "R1 sub result");
        check({7'd0, flags_o}, 16'h0100, "R12 command and update together");

        // R13: reset clears control and status
        apply(4'd0, 1'b0, 16'hFFFF, 16'h0001, 1'b1, 1'b0, 2'd0, 1'b0, 16'h0000, "R1 wrap result");
        check({7'd0, flags_o}, 16'h010F, "R3 carry before reset");
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1; rst = 1'b0;
        check({7'd0, flags_o}, 16'h0000, "R13 reset clears word");

        finish_run();
    end

endmodule